// File: doc/BRIEF.md
# Dual-Mode Automatic Gain Controller

This block sets two gains for a narrow-band receive chain. The first is a coarse analog attenuation code. It moves the converter full-scale reference across a 12 dB span in sixteen codes of 0.8 dB each. The second is a digital gain applied to the decimated I/Q stream. It works as a saturating left shift of 0 to 7 positions, which is 6 dB per position. The digital gain matters most when the downstream format keeps only 16 bits of I and Q.

Each gain has its own mode bit. In manual mode a gain follows the value on its manual input, which software writes. In automatic mode the controller does three things:

- It reacts to the converter clip flag at once.
- It tracks the output power with a first-order averaging filter. The filter's shift constant can be set from 2 to 8.
- Once per sixteen output samples, it moves the gain by one step, so that the average of I²+Q² settles on the square of a programmable reference level.

When the gain must change, the attenuator moves first. The digital gain moves only when the attenuator is at its limit in the needed direction, or when the attenuator is under manual control.

Top module: `gain_loop`

## Requirements
- R1: After reset, att_code_o is 0, dg_shift_o is 0, out_valid_o is 0, and out_i_o and out_q_o are 0.
- R2: With att_auto_i low, att_code_o equals att_man_i one clock later. With dg_auto_i low, dg_shift_o equals dg_man_i one clock later.
- R3: One clock after a sample with smp_valid_i high, out_valid_o is high for one cycle. out_i_o and out_q_o then hold the input shifted left by dg_shift_o, saturated to the range -32768 to +32767.
- R4: In automatic mode the loop makes one decision at the 16th output sample after reset, then at every 16th output sample after that. If the power estimate is above ref_level_i squared, the attenuation code goes up by exactly one, one clock after that output sample. No other output sample changes it.
- R5: For a gain increase, the attenuation code goes down first. The digital shift goes up only when the attenuation code is 0 or att_auto_i is low. For a gain decrease, the digital shift goes down only when the attenuation code is 15 or att_auto_i is low.
- R6: In automatic mode the attenuation code saturates at 15 and 0. The digital shift saturates at 7 and 0.
- R7: A clip_i pulse with att_auto_i high raises the attenuation code by one on the next clock. The code stays at 15 if it is already at 15.
- R8: After a clip_i pulse, no gain increase happens for the next 64 output samples. The first increase can come at the first decision after those 64 samples.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clip_i | input | 1 | Converter clip indication |
| smp_valid_i | input | 1 | Decimated sample strobe |
| smp_i_i | input | 16 | In-phase sample, two's complement |
| smp_q_i | input | 16 | Quadrature sample, two's complement |
| att_auto_i | input | 1 | 1 = attenuation under loop control |
| dg_auto_i | input | 1 | 1 = digital gain under loop control |
| att_man_i | input | 4 | Manual attenuation code |
| dg_man_i | input | 3 | Manual digital shift |
| ref_level_i | input | 16 | Target RMS amplitude, unsigned |
| avg_shift_i | input | 4 | Averaging shift, clamped to 2..8 |
| att_code_o | output | 4 | Attenuation code to the analog reference |
| dg_shift_o | output | 3 | Current digital shift |
| out_valid_o | output | 1 | Scaled sample strobe |
| out_i_o | output | 16 | Scaled in-phase sample |
| out_q_o | output | 16 | Scaled quadrature sample |

## Verification
The assertions check these behaviours on every cycle:

- In automatic mode, neither gain moves by more than one step per clock.
- A clip pulse raises the attenuation.
- While the hold window runs, the attenuation never drops.
- Manual values pass through.
- A zero shift passes samples unchanged.
- The power estimate stays still between samples.

Only the bench scenarios can show the behaviours that depend on whole sequences of samples. These are:

- the exact 16-sample decision cadence;
- the attenuator-first order in both directions;
- the release of a gain increase after exactly 64 samples;
- the saturated output values.

// File: rtl/gain_pkg.sv
package gain_pkg;
    localparam int unsigned SAMPLE_W = 16;
    localparam int unsigned ATT_W    = 4;
    localparam int unsigned SHIFT_W  = 3;
    localparam int unsigned AVG_W    = 4;
    localparam int unsigned AVG_MIN  = 2;
    localparam int unsigned AVG_MAX  = 8;
    localparam int unsigned HOLD_N   = 64;
    localparam int unsigned STEP_N   = 16;

    typedef enum logic [1:0] {
        DIR_KEEP = 2'd0,
        DIR_UP   = 2'd1,
        DIR_DOWN = 2'd2
    } dir_e;
endpackage

// File: rtl/gain_scaler.sv
module gain_scaler #(
    parameter int unsigned DW = gain_pkg::SAMPLE_W,
    parameter int unsigned SW = gain_pkg::SHIFT_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en_i,
    input  logic [SW-1:0]        sh_i,
    input  logic signed [DW-1:0] in_i,
    output logic signed [DW-1:0] out_o
);
    localparam int unsigned SH_MAX = (1 << SW) - 1;
    localparam int unsigned WW     = DW + SH_MAX;

    logic signed [WW-1:0] ext;
    logic signed [WW-1:0] wide;
    logic signed [DW-1:0] data_d, data_q;

    always_comb begin
        ext    = WW'(in_i);
        wide   = ext <<< sh_i;
        data_d = data_q;
        if (en_i) begin
            if ((wide[WW-1:DW-1] == '0) || (wide[WW-1:DW-1] == '1))
                data_d = wide[DW-1:0];
            else if (wide[WW-1])
                data_d = {1'b1, {(DW-1){1'b0}}};
            else
                data_d = {1'b0, {(DW-1){1'b1}}};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) data_q <= '0;
        else        data_q <= data_d;
    end

    assign out_o = data_q;

    // R3: a zero shift passes the sample through unchanged
    p_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && sh_i == '0) |=> (out_o == $past(in_i)));
endmodule

// File: rtl/power_est.sv
module power_est #(
    parameter int unsigned DW    = gain_pkg::SAMPLE_W,
    parameter int unsigned KW    = gain_pkg::AVG_W,
    parameter int unsigned K_MIN = gain_pkg::AVG_MIN,
    parameter int unsigned K_MAX = gain_pkg::AVG_MAX
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 valid_i,
    input  logic signed [DW-1:0] i_i,
    input  logic signed [DW-1:0] q_i,
    input  logic [KW-1:0]        k_i,
    input  logic [DW-1:0]        ref_i,
    output gain_pkg::dir_e       dir_o
);
    localparam int unsigned PW = 2 * DW + 1;

    logic signed [2*DW-1:0] ii, qq;
    logic [PW-1:0]          pwr;
    logic signed [PW:0]     diff, step;
    logic [KW-1:0]          k;
    logic [2*DW-1:0]        tgt;
    logic [PW-1:0]          acc_d, acc_q;

    always_comb begin
        ii   = i_i * i_i;
        qq   = q_i * q_i;
        pwr  = PW'($unsigned(ii)) + PW'($unsigned(qq));
        if (k_i < KW'(K_MIN))      k = KW'(K_MIN);
        else if (k_i > KW'(K_MAX)) k = KW'(K_MAX);
        else                       k = k_i;
        diff  = $signed({1'b0, pwr}) - $signed({1'b0, acc_q});
        step  = diff >>> k;
        acc_d = valid_i ? PW'($signed({1'b0, acc_q}) + step) : acc_q;
        tgt   = ref_i * ref_i;
        if (acc_q > {1'b0, tgt})      dir_o = gain_pkg::DIR_DOWN;
        else if (acc_q < {1'b0, tgt}) dir_o = gain_pkg::DIR_UP;
        else                          dir_o = gain_pkg::DIR_KEEP;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    // R4: the estimate only moves on output samples
    p_est_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(acc_q));
endmodule

// File: rtl/gain_ctrl.sv
module gain_ctrl #(
    parameter int unsigned AW     = gain_pkg::ATT_W,
    parameter int unsigned SW     = gain_pkg::SHIFT_W,
    parameter int unsigned HOLD_N = gain_pkg::HOLD_N,
    parameter int unsigned STEP_N = gain_pkg::STEP_N
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clip_i,
    input  logic           tick_i,
    input  gain_pkg::dir_e dir_i,
    input  logic           att_auto_i,
    input  logic           dg_auto_i,
    input  logic [AW-1:0]  att_man_i,
    input  logic [SW-1:0]  dg_man_i,
    output logic [AW-1:0]  att_o,
    output logic [SW-1:0]  dg_o
);
    localparam logic [AW-1:0] ATT_MAX = '1;
    localparam logic [SW-1:0] DG_MAX  = '1;
    localparam int unsigned   HW      = $clog2(HOLD_N + 1);
    localparam int unsigned   CW      = $clog2(STEP_N);

    typedef struct packed {
        logic [AW-1:0] att;
        logic [SW-1:0] dg;
        logic [HW-1:0] hold;
        logic [CW-1:0] cnt;
    } st_t;

    st_t  st_d, st_q;
    logic decide;

    always_comb begin
        st_d   = st_q;
        decide = tick_i && (st_q.cnt == CW'(STEP_N - 1));
        if (!att_auto_i) st_d.att = att_man_i;
        if (!dg_auto_i)  st_d.dg  = dg_man_i;
        if (tick_i) begin
            st_d.cnt = decide ? '0 : st_q.cnt + 1'b1;
            if (st_q.hold != '0) st_d.hold = st_q.hold - 1'b1;
        end
        if (clip_i) begin
            st_d.hold = HW'(HOLD_N);
            if (att_auto_i && st_q.att != ATT_MAX) st_d.att = st_q.att + 1'b1;
        end else if (decide) begin
            case (dir_i)
                gain_pkg::DIR_DOWN: begin
                    if (att_auto_i && st_q.att != ATT_MAX)
                        st_d.att = st_q.att + 1'b1;
                    else if (dg_auto_i && st_q.dg != '0)
                        st_d.dg = st_q.dg - 1'b1;
                end
                gain_pkg::DIR_UP: begin
                    if (st_q.hold == '0) begin
                        if (att_auto_i && st_q.att != '0)
                            st_d.att = st_q.att - 1'b1;
                        else if (dg_auto_i && st_q.dg != DG_MAX)
                            st_d.dg = st_q.dg + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign att_o = st_q.att;
    assign dg_o  = st_q.dg;

    // R2: manual attenuation is taken over on the next clock
    p_manual_att_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !att_auto_i |=> (st_q.att == $past(att_man_i)));
    // R4: the loop moves attenuation at most one step per clock
    p_att_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        att_auto_i |=> ((st_q.att == $past(st_q.att)) ||
                        (st_q.att == $past(st_q.att) + 1'b1) ||
                        (st_q.att == $past(st_q.att) - 1'b1)));
    // R6: the loop moves the digital shift at most one step per clock
    p_dg_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dg_auto_i |=> ((st_q.dg == $past(st_q.dg)) ||
                       (st_q.dg == $past(st_q.dg) + 1'b1) ||
                       (st_q.dg == $past(st_q.dg) - 1'b1)));
    // R7: a clip raises attenuation right away
    p_clip_up_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clip_i && att_auto_i && st_q.att != ATT_MAX) |=>
        (st_q.att == $past(st_q.att) + 1'b1));
    // R8: no attenuation decrease while the hold window runs
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.hold != '0 && att_auto_i) |=> (st_q.att >= $past(st_q.att)));
endmodule

// File: rtl/gain_loop.sv
module gain_loop #(
    parameter int unsigned DW = gain_pkg::SAMPLE_W,
    parameter int unsigned AW = gain_pkg::ATT_W,
    parameter int unsigned SW = gain_pkg::SHIFT_W,
    parameter int unsigned KW = gain_pkg::AVG_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clip_i,
    input  logic                 smp_valid_i,
    input  logic signed [DW-1:0] smp_i_i,
    input  logic signed [DW-1:0] smp_q_i,
    input  logic                 att_auto_i,
    input  logic                 dg_auto_i,
    input  logic [AW-1:0]        att_man_i,
    input  logic [SW-1:0]        dg_man_i,
    input  logic [DW-1:0]        ref_level_i,
    input  logic [KW-1:0]        avg_shift_i,
    output logic [AW-1:0]        att_code_o,
    output logic [SW-1:0]        dg_shift_o,
    output logic                 out_valid_o,
    output logic signed [DW-1:0] out_i_o,
    output logic signed [DW-1:0] out_q_o
);
    localparam int unsigned NCH = 2;

    logic signed [DW-1:0] ch_in  [NCH];
    logic signed [DW-1:0] ch_out [NCH];
    logic                 vld_d, vld_q;
    gain_pkg::dir_e       dir;

    assign ch_in[0] = smp_i_i;
    assign ch_in[1] = smp_q_i;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        gain_scaler #(.DW(DW), .SW(SW)) u_scl (
            .clk   (clk),
            .rst_n (rst_n),
            .en_i  (smp_valid_i),
            .sh_i  (dg_shift_o),
            .in_i  (ch_in[c]),
            .out_o (ch_out[c])
        );
    end

    always_comb vld_d = smp_valid_i;

    always_ff @(posedge clk) begin
        if (!rst_n) vld_q <= 1'b0;
        else        vld_q <= vld_d;
    end

    power_est #(.DW(DW), .KW(KW)) u_pwr (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (vld_q),
        .i_i     (ch_out[0]),
        .q_i     (ch_out[1]),
        .k_i     (avg_shift_i),
        .ref_i   (ref_level_i),
        .dir_o   (dir)
    );

    gain_ctrl #(.AW(AW), .SW(SW)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .clip_i     (clip_i),
        .tick_i     (vld_q),
        .dir_i      (dir),
        .att_auto_i (att_auto_i),
        .dg_auto_i  (dg_auto_i),
        .att_man_i  (att_man_i),
        .dg_man_i   (dg_man_i),
        .att_o      (att_code_o),
        .dg_o       (dg_shift_o)
    );

    assign out_valid_o = vld_q;
    assign out_i_o     = ch_out[0];
    assign out_q_o     = ch_out[1];

    // R3: each accepted sample yields exactly one output strobe
    p_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid_i |=> out_valid_o);
endmodule

// File: tb/gain_loop_tb_top.sv
module gain_loop_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clip = 1'b0, svld = 1'b0;
    logic signed [15:0] si = '0, sq = '0;
    logic att_auto = 1'b0, dg_auto = 1'b0;
    logic [3:0] att_man = '0;
    logic [2:0] dg_man = '0;
    logic [15:0] ref_lvl = '0;
    logic [3:0] avg_sh = 4'd4;
    logic [3:0] att_code;
    logic [2:0] dg_sh;
    logic ovld;
    logic signed [15:0] oi, oq;

    int n_chk = 0, n_bad = 0;
    bit sb_on = 1'b0;
    int exp_i[$];
    int exp_q[$];

    always #10 clk = ~clk;

    gain_loop dut_i (
        .clk(clk), .rst_n(rst_n), .clip_i(clip), .smp_valid_i(svld),
        .smp_i_i(si), .smp_q_i(sq), .att_auto_i(att_auto), .dg_auto_i(dg_auto),
        .att_man_i(att_man), .dg_man_i(dg_man), .ref_level_i(ref_lvl),
        .avg_shift_i(avg_sh), .att_code_o(att_code), .dg_shift_o(dg_sh),
        .out_valid_o(ovld), .out_i_o(oi), .out_q_o(oq)
    );

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int sat_shl(int x, int sh);
        longint v = longint'(x) <<< sh;
        if (v > 32767)  return 32767;
        if (v < -32768) return -32768;
        return int'(v);
    endfunction

    always @(negedge clk) begin
        if (sb_on && ovld) begin
            if (exp_i.size() == 0) begin
                chk("R3 unexpected strobe", 1, 0);
            end else begin
                chk("R3 I", int'(oi), exp_i.pop_front());
                chk("R3 Q", int'(oq), exp_q.pop_front());
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send(int a, int b);
        @(negedge clk);
        svld = 1'b1;
        si = 16'(a);
        sq = 16'(b);
        if (sb_on) begin
            exp_i.push_back(sat_shl(a, int'(dg_sh)));
            exp_q.push_back(sat_shl(b, int'(dg_sh)));
        end
        @(negedge clk);
        svld = 1'b0;
    endtask

    task automatic send_n(int n, int a, int b);
        for (int k = 0; k < n; k++) send(a, b);
        @(negedge clk);
    endtask

    task automatic pulse_clip();
        @(negedge clk);
        clip = 1'b1;
        @(negedge clk);
        clip = 1'b0;
    endtask

    initial begin
        #(200000 * 20);
        chk("watchdog", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 att", int'(att_code), 0);
        chk("R1 dg", int'(dg_sh), 0);
        chk("R1 valid", int'(ovld), 0);
        chk("R1 out", int'(oi), 0);

        // R2 manual values, R3 scaling and saturation
        att_man = 4'd5; dg_man = 3'd3;
        repeat (2) @(negedge clk);
        chk("R2 att manual", int'(att_code), 5);
        chk("R2 dg manual", int'(dg_sh), 3);
        sb_on = 1'b1;
        send(100, -7);
        send(5000, -5000);
        send(-1, 4095);
        dg_man = 3'd0;
        repeat (2) @(negedge clk);
        send(32767, -32768);
        dg_man = 3'd7;
        repeat (2) @(negedge clk);
        chk("R2 dg manual 7", int'(dg_sh), 7);
        send(1, 300);
        send(-256, -257);
        @(negedge clk);
        sb_on = 1'b0;
        chk("R3 queue drained", exp_i.size(), 0);

        // R4 decision cadence, loud signal, zero reference
        do_reset();
        att_auto = 1'b1; dg_auto = 1'b0; dg_man = 3'd0; ref_lvl = 16'd0;
        send_n(15, 20000, 20000);
        chk("R4 no step before 16th", int'(att_code), 0);
        send_n(1, 20000, 20000);
        chk("R4 first step", int'(att_code), 1);
        send_n(16, 20000, 20000);
        chk("R4 second step", int'(att_code), 2);
        send_n(13 * 16, 20000, 20000);
        chk("R6 att at 15", int'(att_code), 15);
        send_n(16, 20000, 20000);
        chk("R6 att saturates", int'(att_code), 15);
        pulse_clip();
        chk("R7 clip at max", int'(att_code), 15);
        // R5 decrease digital only once attenuation is at 15
        dg_man = 3'd3;
        repeat (2) @(negedge clk);
        dg_auto = 1'b1;
        send_n(16, 20000, 20000);
        chk("R5 dg down at att max", int'(dg_sh), 2);
        chk("R5 att held at max", int'(att_code), 15);

        // R5 increase: attenuation first, then digital
        do_reset();
        att_auto = 1'b0; att_man = 4'd8; dg_auto = 1'b1; ref_lvl = 16'hFFFF;
        repeat (2) @(negedge clk);
        att_auto = 1'b1;
        send_n(16, 1, 1);
        chk("R5 att first", int'(att_code), 7);
        chk("R5 dg untouched", int'(dg_sh), 0);
        send_n(7 * 16, 1, 1);
        chk("R5 att at min", int'(att_code), 0);
        chk("R5 dg still 0", int'(dg_sh), 0);
        send_n(16, 1, 1);
        chk("R5 dg up at att min", int'(dg_sh), 1);
        send_n(6 * 16, 1, 1);
        chk("R6 dg at 7", int'(dg_sh), 7);
        send_n(32, 1, 1);
        chk("R6 dg saturates", int'(dg_sh), 7);

        // R7 clip step and R8 hold window
        do_reset();
        att_auto = 1'b1; dg_auto = 1'b0; dg_man = 3'd0; ref_lvl = 16'hFFFF;
        pulse_clip();
        chk("R7 clip raises att", int'(att_code), 1);
        send_n(64, 1, 1);
        chk("R8 held through 64", int'(att_code), 1);
        send_n(16, 1, 1);
        chk("R8 released", int'(att_code), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule